// File: doc/BRIEF.md
# Longword-to-Word Register Access Splitter

This block connects a 32-bit bus master to a register space that is only 16 bits wide. It accepts one request at a time from the master. Each request is either a halfword access or a full 32-bit access, and either a read or a write. The block turns the request into word bus cycles of fixed length, each lasting `CYC_CLKS` clocks (at least three).

A halfword request produces one such cycle. A 32-bit request produces two cycles that run back to back. The upper halfword is transferred first, at the lower address, and the lower halfword follows at the address two bytes higher. A lock line stays high across both halves so that no other master can use the register space between them. The same split applies to reads and writes.

When the last word cycle of a request ends, the master gets a single-clock ready pulse. On a 32-bit read, the halfword returned by the first cycle is held until the second arrives, and the two are presented together as one 32-bit value. The master issues a new request only after the previous one has been acknowledged. A request strobe raised while a transfer is in progress is dropped.

Top module: `wsplit_bridge`

## Requirements
- R1: While reset is high and on the first clock after it, `bus_sel`, `bus_stb`, `bus_lock` and `cpu_ready` are 0 and `cpu_rdata` is 0.
- R2: A halfword request (`cpu_long`=0) gives exactly one word cycle: `bus_sel` high for exactly `CYC_CLKS` consecutive clocks, with `bus_addr` equal to `cpu_addr` with bit 0 cleared and `bus_wdata` equal to `cpu_wdata[15:0]`.
- R3: A 32-bit request (`cpu_long`=1) gives two word cycles with no gap between them: `bus_sel` stays high for exactly 2×`CYC_CLKS` consecutive clocks.
- R4: In a 32-bit request the first cycle uses the address with bits 1:0 cleared and carries `cpu_wdata[31:16]`. The second cycle uses that address plus 2 and carries `cpu_wdata[15:0]`.
- R5: `bus_lock` is high on every clock of both cycles of a 32-bit request and low on every clock of a halfword request.
- R6: `cpu_ready` is high for exactly one clock per request, on the clock right after the last `bus_sel` clock.
- R7: On a 32-bit read, `cpu_rdata` = {first cycle's `bus_rdata`, second cycle's `bus_rdata`}. On a halfword read, it is {16'h0000, `bus_rdata`}. In both cases `bus_rdata` is sampled on the final clock of each cycle.
- R8: A `cpu_req` pulse while a request is in progress is ignored: no extra word cycle appears and the current transfer's address, direction and data are unchanged.
- R9: `bus_stb` is high only on the first clock of each word cycle. `bus_we`, `bus_addr` and `bus_wdata` hold steady for the whole cycle, and `bus_we` matches the request's direction on both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-clock request strobe from the master |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_long | input | 1 | 1 = 32-bit access, 0 = halfword access |
| cpu_addr | input | AW | Byte address of the request |
| cpu_wdata | input | 32 | Write data (halfword access uses bits 15:0) |
| cpu_rdata | output | 32 | Assembled read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-clock completion pulse |
| bus_sel | output | 1 | High for every clock of a word cycle |
| bus_stb | output | 1 | High on the first clock of each word cycle |
| bus_lock | output | 1 | Holds off other masters across a split access |
| bus_we | output | 1 | Direction of the current word cycle |
| bus_addr | output | AW | Halfword-aligned byte address of the current cycle |
| bus_wdata | output | 16 | Write halfword of the current cycle |
| bus_rdata | input | 16 | Read halfword from the register space |

## Verification
The assertions assume that the register space drives `bus_rdata` as a function of `bus_addr` by the final clock of every cycle. They also assume that the master raises `cpu_req` for a single clock and otherwise waits for `cpu_ready`. The stimulus stays within these assumptions. Its register model is a pure function of the address. Its driver raises the strobe for one clock and waits for the ready pulse before the next request. The only exception is a deliberate second strobe placed in the middle of a transfer, which exercises the ignore rule.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_FINAL = 2'd2
  } phase_t;
endpackage

// File: rtl/wsplit_timer.sv
module wsplit_timer #(
  parameter int CYC_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 2;
  localparam logic [CW-1:0] TOP = CW'(CYC_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == TOP);

  // R2: the in-cycle counter never exceeds the final clock index
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  // R2: the counter rests at zero outside a cycle
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |-> cnt == '0);
endmodule

// File: rtl/wsplit_seq.sv
module wsplit_seq
  import wsplit_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_long,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  logic          cyc_last,
  output logic          bus_sel,
  output logic          bus_stb,
  output logic          bus_lock,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  output logic          in_first
);
  localparam logic [AW-1:0] LONG_MASK = AW'(3);
  localparam logic [AW-1:0] WORD_MASK = AW'(1);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  phase_t      phase;
  logic [15:0] low_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bus_sel   <= 1'b0;
      bus_stb   <= 1'b0;
      bus_lock  <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      low_half  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          bus_stb <= 1'b0;
          if (cpu_req) begin
            phase     <= cpu_long ? PH_FIRST : PH_FINAL;
            bus_sel   <= 1'b1;
            bus_stb   <= 1'b1;
            bus_lock  <= cpu_long;
            bus_we    <= cpu_we;
            bus_addr  <= cpu_addr & ~(cpu_long ? LONG_MASK : WORD_MASK);
            bus_wdata <= cpu_long ? cpu_wdata[31:16] : cpu_wdata[15:0];
            low_half  <= cpu_wdata[15:0];
          end
        end
        PH_FIRST: begin
          bus_stb <= 1'b0;
          if (cyc_last) begin
            phase     <= PH_FINAL;
            bus_stb   <= 1'b1;
            bus_addr  <= bus_addr + HALF_STEP;
            bus_wdata <= low_half;
          end
        end
        PH_FINAL: begin
          bus_stb <= 1'b0;
          if (cyc_last) begin
            phase    <= PH_IDLE;
            bus_sel  <= 1'b0;
            bus_lock <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign in_first = (phase == PH_FIRST);

  // R9: direction, address and data hold through a cycle after its first clock
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_stb) |-> ($stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
  // R9: strobe only inside a selected cycle
  a_r9_stb_in_sel: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_sel);
  // R4: the second half follows two bytes above the first
  a_r4_second_addr: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_lock && $past(bus_sel)) |-> bus_addr == $past(bus_addr) + HALF_STEP);
  // R8: direction does not change inside a locked transfer
  a_r8_we_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && $past(bus_lock)) |-> $stable(bus_we));
endmodule

// File: rtl/wsplit_merge.sv
module wsplit_merge (
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc_last,
  input  logic        in_first,
  input  logic        is_long,
  input  logic [15:0] bus_rdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready
);
  logic [15:0] upper_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_hold <= '0;
      cpu_rdata  <= '0;
      cpu_ready  <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      if (cyc_last) begin
        if (in_first) begin
          upper_hold <= bus_rdata;
        end else begin
          cpu_ready <= 1'b1;
          cpu_rdata <= is_long ? {upper_hold, bus_rdata} : {16'h0000, bus_rdata};
        end
      end
    end
  end

  // R6: completion is a single-clock pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/wsplit_bridge.sv
module wsplit_bridge #(
  parameter int AW       = 8,
  parameter int CYC_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_long,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_ready,
  output logic          bus_sel,
  output logic          bus_stb,
  output logic          bus_lock,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata
);
  logic cyc_last;
  logic in_first;

  wsplit_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (bus_sel),
    .last (cyc_last)
  );

  wsplit_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_long  (cpu_long),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cyc_last  (cyc_last),
    .bus_sel   (bus_sel),
    .bus_stb   (bus_stb),
    .bus_lock  (bus_lock),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .in_first  (in_first)
  );

  wsplit_merge u_merge (
    .clk       (clk),
    .rst       (rst),
    .cyc_last  (cyc_last),
    .in_first  (in_first),
    .is_long   (bus_lock),
    .bus_rdata (bus_rdata),
    .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready)
  );

  // R5: the lock is only ever raised inside a selected cycle
  a_r5_lock_in_sel: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> bus_sel);
  // R6: ready follows the clock on which the last cycle ended
  a_r6_ready_after_sel: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> ($past(bus_sel) && !bus_sel));
  // R3: a locked transfer never drops select between its halves
  a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && !bus_stb) |=> (bus_sel || cpu_ready));
endmodule

// File: tb/wsplit_bridge_test.sv
module wsplit_bridge_test;
  localparam int AW  = 8;
  localparam int CYC = 3;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          we;
    logic [15:0]   wd;
    logic          lock;
  } cyc_t;

  typedef struct packed {
    logic        is_read;
    logic [31:0] rd;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_long = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic cpu_ready, bus_sel, bus_stb, bus_lock, bus_we;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  cyc_t cyc_q[$];
  int   run_q[$];
  res_t res_q[$];

  always #5 clk = ~clk;

  function automatic logic [15:0] regval(input logic [AW-1:0] a);
    return {~a, a ^ 8'h3C};
  endfunction

  assign bus_rdata = regval(bus_addr);

  wsplit_bridge #(.AW(AW), .CYC_CLKS(CYC)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_long(cpu_long),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .bus_sel(bus_sel), .bus_stb(bus_stb), .bus_lock(bus_lock),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares bus cycles, run lengths and results against the queues
  cyc_t cur;
  logic prev_sel = 1'b0;
  int   runlen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_stb) begin
        if (cyc_q.size() == 0) begin
          check("R8 unexpected word cycle", 32'(bus_addr), 32'hFFFF_FFFF);
        end else begin
          cur = cyc_q.pop_front();
          check("R4 cycle address", 32'(bus_addr), 32'(cur.addr));
          check("R9 cycle direction", 32'(bus_we), 32'(cur.we));
          if (cur.we) check("R2 write halfword", 32'(bus_wdata), 32'(cur.wd));
        end
      end
      if (bus_sel) begin
        check("R5 lock level", 32'(bus_lock), 32'(cur.lock));
        check("R9 address held", 32'(bus_addr), 32'(cur.addr));
        runlen = prev_sel ? runlen + 1 : 1;
      end
      if (!bus_sel && prev_sel) begin
        if (run_q.size() == 0) check("R3 unexpected select run", 32'(runlen), 32'd0);
        else check("R3 select run length", 32'(runlen), 32'(run_q.pop_front()));
      end
      if (cpu_ready) begin
        check("R6 ready after last select", 32'(prev_sel && !bus_sel), 32'd1);
        if (res_q.size() == 0) begin
          check("R6 unexpected ready", 32'd1, 32'd0);
        end else begin
          res_t r;
          r = res_q.pop_front();
          if (r.is_read) check("R7 read data", cpu_rdata, r.rd);
        end
      end
      prev_sel = bus_sel;
    end
  end

  task automatic access(input logic we, input logic lng, input logic [AW-1:0] a,
                        input logic [31:0] wd, input bit poke);
    logic [AW-1:0] base;
    res_t r;
    base = a & (lng ? 8'hFC : 8'hFE);
    cyc_q.push_back('{addr: base, we: we, wd: lng ? wd[31:16] : wd[15:0], lock: lng});
    if (lng) cyc_q.push_back('{addr: base + 8'd2, we: we, wd: wd[15:0], lock: 1'b1});
    run_q.push_back(lng ? 2 * CYC : CYC);
    r.is_read = !we;
    r.rd = lng ? {regval(base), regval(base + 8'd2)} : {16'h0000, regval(base)};
    res_q.push_back(r);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_long = lng; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (poke) begin
      @(negedge clk);
      // R8: a strobe mid-transfer with different fields must be dropped
      cpu_req = 1'b1; cpu_we = !we; cpu_long = !lng; cpu_addr = a ^ 8'h40; cpu_wdata = ~wd;
      @(negedge clk);
      cpu_req = 1'b0;
    end
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    check("R6 ready lasts one clock", 32'(cpu_ready), 32'd0);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog R6 actual=no completion expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1 sel in reset", 32'(bus_sel), 32'd0);
    check("R1 lock in reset", 32'(bus_lock), 32'd0);
    check("R1 ready in reset", 32'(cpu_ready), 32'd0);
    check("R1 rdata in reset", cpu_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stb after reset", 32'(bus_stb), 32'd0);
    check("R1 sel after reset", 32'(bus_sel), 32'd0);

    access(1'b1, 1'b0, 8'h11, 32'hDEAD_BEEF, 1'b0); // R2 halfword write, bit 0 cleared
    access(1'b0, 1'b0, 8'h24, 32'h0, 1'b0);         // R2 R7 halfword read
    access(1'b1, 1'b1, 8'h32, 32'h1234_5678, 1'b0); // R3 R4 32-bit write, low bits cleared
    access(1'b0, 1'b1, 8'h48, 32'h0, 1'b0);         // R7 32-bit read
    access(1'b0, 1'b1, 8'hFF, 32'h0, 1'b0);         // R4 top of address space
    access(1'b0, 1'b1, 8'h80, 32'h0, 1'b0);         // back-to-back 32-bit reads
    access(1'b0, 1'b1, 8'h84, 32'h0, 1'b0);
    access(1'b0, 1'b0, 8'h07, 32'h0, 1'b1);         // R8 poke during halfword read
    access(1'b1, 1'b1, 8'h60, 32'hCAFE_F00D, 1'b1); // R8 poke during 32-bit write
    access(1'b0, 1'b1, 8'h0C, 32'h0, 1'b1);         // R8 poke during 32-bit read

    repeat (8) @(negedge clk);
    check("R8 no extra cycles pending", 32'(cyc_q.size()), 32'd0);
    check("R8 no extra results pending", 32'(res_q.size()), 32'd0);
    check("R3 no run lengths pending", 32'(run_q.size()), 32'd0);
    check("R8 bus idle at end", 32'(bus_sel), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule